// File: doc/BRIEF.md
# Imprecise Error Collector with Interrupt

This block collects error responses in a coherent interconnect that cannot be sent back on the response to the request that caused them. Each interface of the interconnect delivers one strobe per response, together with the error bit and flags that describe the response. A snoop response is reported by the requester-facing (slave) interface that received it. A write response is reported by the memory-facing (master) interface that received it. A fixed set of rules decides whether each error is recorded here, and which interface it is charged to. Some snoop errors are charged to a master interface and not to the slave interface that returned the snoop response.

Each interface has its own sticky bit in a status register that software can read. Software clears bits by writing ones to them. An active-low interrupt output stays asserted while any status bit is set. The status bits occupy positions 0 to NUM_SLV-1 for slave interfaces, and NUM_SLV to NUM_SLV+NUM_MST-1 for master interfaces (master j at bit NUM_SLV+j).

Snoop cause codes on `snp_cause` are:
- 2'b00: ordinary coherent request.
- 2'b01: unique write (full-line or partial).
- 2'b10: back-invalidation.
- 2'b11: never driven.

Top module: `ierr_collector`

## Requirements
- R1: After reset, `status_rd` is all zero and `irq_n` is 1.
- R2: A snoop response on slave interface i with `snp_vld`, `snp_err` set, cause 2'b00 and `snp_hit` clear sets status bit i on the next clock edge.
- R3: A snoop response on slave i with error, cause 2'b00, `snp_hit` set and `snp_own` clear (data from another snooped master was used) sets status bit i.
- R4: A snoop response with error, cause 2'b00, `snp_hit` set and `snp_own` set (its own data was used) changes no status bit.
- R5: A snoop response with error and cause 2'b01 sets master bit NUM_SLV+`snp_mst` of that slave, and does not set slave bit i.
- R6: A snoop response with error and cause 2'b10 sets slave bit i, whatever the hit and own-data flags are.
- R7: A write response on master interface j with `wr_vld`, `wr_err` and `wr_internal` set sets bit NUM_SLV+j. The same response with `wr_internal` clear changes no status bit.
- R8: Responses whose error bit is clear change no status bit.
- R9: Status bits stay set until cleared. When `clr_we` is high, every bit set in `clr_mask` is cleared on the next edge. Mask bits at 0 leave their status bits unchanged.
- R10: An event that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R11: `irq_n` is 0 exactly when `status_rd` is non-zero, and it changes on the same edge as the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_vld | input | NUM_SLV | Snoop response strobe, one per slave interface |
| snp_err | input | NUM_SLV | Error bit of the snoop response |
| snp_hit | input | NUM_SLV | Snoop hit (1) or miss (0) |
| snp_own | input | NUM_SLV | On a hit, this response's data was the data used |
| snp_cause | input | 2*NUM_SLV | Cause code of the snoop, 2 bits per slave |
| snp_mst | input | MIDX_W*NUM_SLV | Master interface of the unique write that caused the snoop |
| wr_vld | input | NUM_MST | Write response strobe, one per master interface |
| wr_err | input | NUM_MST | Error bit of the write response |
| wr_internal | input | NUM_MST | Write was generated by the interconnect itself |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | NUM_SLV+NUM_MST | Write-one-to-clear mask |
| status_rd | output | NUM_SLV+NUM_MST | Sticky status bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The checker assumes three things about its inputs. A valid snoop never carries the reserved cause code 2'b11. The master index on a unique-write snoop always names an existing master interface. The context flags are only meaningful when the matching strobe is high. The stimulus keeps to these limits: it uses only the three defined cause codes and master indices below NUM_MST, and it drives the flags to zero on every idle cycle. Under those limits, the checker relates each rising status bit to a qualifying event on the previous cycle, and each clear to the mask that was written.

// File: rtl/ierr_pkg.sv
// Package: shared types for the imprecise error collector.
// Assumes: cause code 2'b11 is never driven with a valid snoop.
package ierr_pkg;

    typedef enum logic [1:0] {
        CAUSE_REQ   = 2'b00,
        CAUSE_WUNIQ = 2'b01,
        CAUSE_BINV  = 2'b10,
        CAUSE_RSVD  = 2'b11
    } snp_cause_e;

    // Width of a master-interface index; at least one bit.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/ierr_slv_classify.sv
// Module: decides where a snoop response error on one slave interface is charged.
// Assumes: flags are only meaningful while vld is high; mst_idx < NUM_MST.
module ierr_slv_classify
    import ierr_pkg::*;
#(
    parameter int NUM_MST = 3,
    parameter int MIDX_W  = 2
) (
    input  logic               vld,
    input  logic               err,
    input  logic               hit,
    input  logic               own,
    input  snp_cause_e         cause,
    input  logic [MIDX_W-1:0]  mst_idx,
    output logic               slv_set,
    output logic [NUM_MST-1:0] mst_set
);

    logic bad;
    logic wuniq;

    assign bad   = vld && err;
    assign wuniq = bad && (cause == CAUSE_WUNIQ);

    // Charge the error to this slave interface unless it is precise or unique-write caused.
    always_comb begin
        slv_set = 1'b0;
        if (bad) begin
            unique case (cause)
                CAUSE_BINV:  slv_set = 1'b1;
                CAUSE_WUNIQ: slv_set = 1'b0;
                default:     slv_set = !(hit && own);
            endcase
        end
    end

    // Steer unique-write snoop errors to the master interface named by the index.
    for (genvar j = 0; j < NUM_MST; j++) begin : g_mst
        assign mst_set[j] = wuniq && (mst_idx == MIDX_W'(j));
    end

endmodule

// File: rtl/ierr_mst_classify.sv
// Module: flags a write response error on one master interface for recording.
// Assumes: errors on writes issued on behalf of a requester are reported precisely elsewhere.
module ierr_mst_classify (
    input  logic vld,
    input  logic err,
    input  logic internal,
    output logic set
);

    // Only writes the interconnect generated itself have no requester to tell.
    assign set = vld && err && internal;

endmodule

// File: rtl/ierr_status_reg.sv
// Module: sticky write-one-to-clear status bits and a registered active-low interrupt.
// Assumes: set and clear vectors are aligned bit for bit; set wins over clear.
module ierr_status_reg #(
    parameter int ST_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_vec,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] status,
    output logic            irq_n
);

    logic [ST_W-1:0] status_q;
    logic [ST_W-1:0] status_d;
    logic            irq_n_q;

    // Next state: drop cleared bits, then add the new events on top.
    always_comb begin
        status_d = status_q;
        if (clr_we) begin
            status_d = status_d & ~clr_mask;
        end
        status_d = status_d | set_vec;
    end

    // Hold the status bits and the interrupt, both from the same next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_n_q  <= 1'b1;
        end else begin
            status_q <= status_d;
            irq_n_q  <= ~(|status_d);
        end
    end

    assign status = status_q;
    assign irq_n  = irq_n_q;

endmodule

// File: rtl/ierr_collector.sv
// Module: top of the imprecise error collector.
// Classifies every interface's responses, merges them into one set vector, and keeps sticky status.
// Assumes: all inputs are synchronous to clk; slave bits sit below master bits in the status word.
module ierr_collector
    import ierr_pkg::*;
#(
    parameter int NUM_SLV = 4,
    parameter int NUM_MST = 3,
    localparam int ST_W   = NUM_SLV + NUM_MST,
    localparam int MIDX_W = ierr_pkg::idx_width(NUM_MST)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLV-1:0]        snp_vld,
    input  logic [NUM_SLV-1:0]        snp_err,
    input  logic [NUM_SLV-1:0]        snp_hit,
    input  logic [NUM_SLV-1:0]        snp_own,
    input  logic [2*NUM_SLV-1:0]      snp_cause,
    input  logic [MIDX_W*NUM_SLV-1:0] snp_mst,
    input  logic [NUM_MST-1:0]        wr_vld,
    input  logic [NUM_MST-1:0]        wr_err,
    input  logic [NUM_MST-1:0]        wr_internal,
    input  logic                      clr_we,
    input  logic [ST_W-1:0]           clr_mask,
    output logic [ST_W-1:0]           status_rd,
    output logic                      irq_n
);

    logic [NUM_SLV-1:0] slv_set;
    logic [NUM_MST-1:0] wr_set;
    logic [NUM_MST-1:0] wu_set [NUM_SLV];
    logic [NUM_MST-1:0] wu_any;
    logic [ST_W-1:0]    set_vec;

    // One snoop classifier per slave interface.
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
        ierr_slv_classify #(
            .NUM_MST (NUM_MST),
            .MIDX_W  (MIDX_W)
        ) u_cls (
            .vld     (snp_vld[i]),
            .err     (snp_err[i]),
            .hit     (snp_hit[i]),
            .own     (snp_own[i]),
            .cause   (snp_cause_e'(snp_cause[2*i +: 2])),
            .mst_idx (snp_mst[MIDX_W*i +: MIDX_W]),
            .slv_set (slv_set[i]),
            .mst_set (wu_set[i])
        );
    end

    // One write response classifier per master interface.
    for (genvar j = 0; j < NUM_MST; j++) begin : g_mst
        ierr_mst_classify u_cls (
            .vld      (wr_vld[j]),
            .err      (wr_err[j]),
            .internal (wr_internal[j]),
            .set      (wr_set[j])
        );
    end

    // Merge unique-write snoop charges from all slaves onto the master bits.
    always_comb begin
        wu_any = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            wu_any = wu_any | wu_set[i];
        end
    end

    // Build the status-aligned set vector.
    assign set_vec = {wr_set | wu_any, slv_set};

    ierr_status_reg #(
        .ST_W (ST_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .status   (status_rd),
        .irq_n    (irq_n)
    );

endmodule

// File: rtl/ierr_collector_chk.sv
// Module: assertion checker bound to ierr_collector.
// Assumes: legal cause codes and master indices on valid snoops (checked as input assumptions).
module ierr_collector_chk #(
    parameter int NUM_SLV = 4,
    parameter int NUM_MST = 3,
    localparam int ST_W   = NUM_SLV + NUM_MST,
    localparam int MIDX_W = ierr_pkg::idx_width(NUM_MST)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SLV-1:0]        snp_vld,
    input logic [NUM_SLV-1:0]        snp_err,
    input logic [2*NUM_SLV-1:0]      snp_cause,
    input logic [MIDX_W*NUM_SLV-1:0] snp_mst,
    input logic [NUM_MST-1:0]        wr_vld,
    input logic [NUM_MST-1:0]        wr_err,
    input logic [NUM_MST-1:0]        wr_internal,
    input logic                      clr_we,
    input logic [ST_W-1:0]           clr_mask,
    input logic [ST_W-1:0]           status_rd,
    input logic                      irq_n
);

    logic any_evt;
    logic wu_any;

    // Summaries of the input events that may set bits.
    always_comb begin
        any_evt = |(wr_vld & wr_err);
        wu_any  = 1'b0;
        for (int i = 0; i < NUM_SLV; i++) begin
            any_evt = any_evt | (snp_vld[i] & snp_err[i]);
            wu_any  = wu_any | (snp_vld[i] & snp_err[i] & (snp_cause[2*i +: 2] == 2'b01));
        end
    end

    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (status_rd == '0)); // R11

    AST_STICKY_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status_rd & $past(status_rd)) == $past(status_rd))); // R9

    AST_CLEAR_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !any_evt) |=> ((status_rd & $past(clr_mask)) == '0)); // R9

    AST_NO_SET_WITHOUT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> ((status_rd & ~$past(status_rd)) == '0)); // R8

    for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
        AST_INPUT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            snp_vld[i] |-> ((snp_cause[2*i +: 2] != 2'b11)
                            && (int'(snp_mst[MIDX_W*i +: MIDX_W]) < NUM_MST))); // R5

        AST_SLV_BIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (status_rd[i] && !$past(status_rd[i])) |->
                $past(snp_vld[i] && snp_err[i] && (snp_cause[2*i +: 2] != 2'b01))); // R5
    end

    for (genvar j = 0; j < NUM_MST; j++) begin : g_mst
        AST_MST_BIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            (status_rd[NUM_SLV+j] && !$past(status_rd[NUM_SLV+j])) |->
                $past((wr_vld[j] && wr_err[j] && wr_internal[j]) || wu_any)); // R7
    end

endmodule

bind ierr_collector ierr_collector_chk #(
    .NUM_SLV (NUM_SLV),
    .NUM_MST (NUM_MST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_vld     (snp_vld),
    .snp_err     (snp_err),
    .snp_cause   (snp_cause),
    .snp_mst     (snp_mst),
    .wr_vld      (wr_vld),
    .wr_err      (wr_err),
    .wr_internal (wr_internal),
    .clr_we      (clr_we),
    .clr_mask    (clr_mask),
    .status_rd   (status_rd),
    .irq_n       (irq_n)
);

// File: tb/ierr_collector_tb.sv
// Scoreboard bench: each driven cycle pushes its expected status; a monitor pops after the edge.
`timescale 1ns/1ps
module ierr_collector_tb;

    localparam int NS   = 4;
    localparam int NM   = 3;
    localparam int ST_W = NS + NM;
    localparam int MW   = 2;

    typedef struct {
        logic [ST_W-1:0] st;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    snp_vld = '0, snp_err = '0, snp_hit = '0, snp_own = '0;
    logic [2*NS-1:0]  snp_cause = '0;
    logic [MW*NS-1:0] snp_mst = '0;
    logic [NM-1:0]    wr_vld = '0, wr_err = '0, wr_internal = '0;
    logic             clr_we = 1'b0;
    logic [ST_W-1:0]  clr_mask = '0;
    logic [ST_W-1:0]  status_rd;
    logic             irq_n;

    // Staging copies filled by the helper tasks, applied by step().
    logic [NS-1:0]    s_vld = '0, s_err = '0, s_hit = '0, s_own = '0;
    logic [2*NS-1:0]  s_cause = '0;
    logic [MW*NS-1:0] s_mst = '0;
    logic [NM-1:0]    w_vld = '0, w_err = '0, w_int = '0;
    logic             c_we = 1'b0;
    logic [ST_W-1:0]  c_mask = '0;

    logic [ST_W-1:0] model = '0;
    exp_t            sb[$];
    int              total = 0;
    int              bad = 0;
    bit              done = 0;

    always #2.5 clk = ~clk;

    ierr_collector u_dut (
        .clk (clk), .rst_n (rst_n),
        .snp_vld (snp_vld), .snp_err (snp_err), .snp_hit (snp_hit), .snp_own (snp_own),
        .snp_cause (snp_cause), .snp_mst (snp_mst),
        .wr_vld (wr_vld), .wr_err (wr_err), .wr_internal (wr_internal),
        .clr_we (clr_we), .clr_mask (clr_mask),
        .status_rd (status_rd), .irq_n (irq_n)
    );

    task automatic add_snp(input int i, input bit err, input bit hit, input bit own,
                           input logic [1:0] cause, input int mst);
        s_vld[i] = 1'b1; s_err[i] = err; s_hit[i] = hit; s_own[i] = own;
        s_cause[2*i +: 2] = cause;
        s_mst[MW*i +: MW] = MW'(mst);
    endtask

    task automatic add_wr(input int j, input bit err, input bit internal);
        w_vld[j] = 1'b1; w_err[j] = err; w_int[j] = internal;
    endtask

    task automatic add_clr(input logic [ST_W-1:0] mask);
        c_we = 1'b1; c_mask = mask;
    endtask

    // Driver: apply staged inputs at the falling edge and push the expected status.
    task automatic step(input string tag);
        logic [ST_W-1:0] set;
        exp_t e;
        @(negedge clk);
        snp_vld = s_vld; snp_err = s_err; snp_hit = s_hit; snp_own = s_own;
        snp_cause = s_cause; snp_mst = s_mst;
        wr_vld = w_vld; wr_err = w_err; wr_internal = w_int;
        clr_we = c_we; clr_mask = c_mask;
        set = '0;
        for (int i = 0; i < NS; i++) begin
            if (s_vld[i] && s_err[i]) begin
                case (s_cause[2*i +: 2])
                    2'b01:   set[NS + int'(s_mst[MW*i +: MW])] = 1'b1;
                    2'b10:   set[i] = 1'b1;
                    default: if (!(s_hit[i] && s_own[i])) set[i] = 1'b1;
                endcase
            end
        end
        for (int j = 0; j < NM; j++) begin
            if (w_vld[j] && w_err[j] && w_int[j]) set[NS+j] = 1'b1;
        end
        model = (model & ~(c_we ? c_mask : '0)) | set;
        e.st = model; e.tag = tag;
        sb.push_back(e);
        s_vld = '0; s_err = '0; s_hit = '0; s_own = '0; s_cause = '0; s_mst = '0;
        w_vld = '0; w_err = '0; w_int = '0; c_we = 1'b0; c_mask = '0;
    endtask

    // Monitor: after each rising edge, compare status and interrupt against the queue head.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (status_rd !== e.st) begin
                bad++;
                $display("FAIL %s status actual=%b expected=%b", e.tag, status_rd, e.st);
            end
            total++;
            if (irq_n !== (e.st == '0)) begin
                bad++;
                $display("FAIL R11 (%s) irq_n actual=%b expected=%b", e.tag, irq_n, (e.st == '0));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (status_rd !== '0 || irq_n !== 1'b1) begin
            bad++;
            $display("FAIL R1 status=%b irq_n=%b expected=0/1", status_rd, irq_n);
        end
        @(negedge clk);
        rst_n = 1'b1;

        add_snp(0, 1, 0, 0, 2'b00, 0);                 step("R2 miss error slave0");
        step("R11 idle holds");
        add_clr(7'b0000001);                           step("R9 clear bit0");
        add_snp(2, 1, 1, 0, 2'b00, 0);                 step("R3 hit other data slave2");
        add_snp(1, 1, 1, 1, 2'b00, 0);                 step("R4 own data precise");
        for (int i = 0; i < NS; i++) add_snp(i, 0, i[0], 0, 2'(i % 3), 1);
        add_wr(0, 0, 1); add_wr(1, 0, 1);              step("R8 no error bits");
        add_snp(3, 1, 0, 0, 2'b01, 2);                 step("R5 unique write to master2");
        add_snp(1, 1, 1, 1, 2'b10, 0);                 step("R6 back-invalidation slave1");
        add_wr(0, 1, 1);                               step("R7 internal write error m0");
        add_wr(1, 1, 0);                               step("R7 requester write ignored");
        add_clr('0);                                   step("R9 zero mask no effect");
        add_clr('1); add_snp(2, 1, 0, 0, 2'b00, 0);    step("R10 set beats clear");
        add_clr(7'b0000100);                           step("R9 clear last bit");
        add_snp(0, 1, 1, 0, 2'b10, 0); add_snp(1, 1, 0, 0, 2'b01, 1);
        add_wr(2, 1, 1);                               step("R5 R6 R7 mixed same cycle");
        add_clr(7'b0100000); add_snp(3, 1, 0, 0, 2'b01, 1); step("R10 unique write beats clear");
        add_clr('1);                                   step("R9 clear all");
        step("R11 idle after clear");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule